// File: doc/BRIEF.md
# Local/Shared Execution Mode Switch

This block owns the execution-mode state of a core. The core can run code from a 512-word local register memory or from a wide shared memory. The block does not use separate instructions for each space. Instead, every jump, call and return carries a 32-bit target, and the block classifies that target. If any bit above the local index range is set, the target is a shared-memory address. Otherwise it is a local address.

The block holds three pieces of state: the mode flag, a 9-bit local program counter and a 32-bit shared pointer. It drives the active PC to the fetch stage. When a call is taken, it hands a 32-bit return value either to a stack (plain call) or to a destination register (register-linked call). That return value is always the full address of the next sequential instruction. A later return through either path therefore lands in the correct space and mode. This holds even when the call was the last word of a fetch window in shared memory.

Top module: `xm_mode_switch`

## Requirements
- R1: After reset the core is in local mode (isShared=0). curPc is 0, sharedPtr is 0 and saveValid is 0.
- R2: A taken branch of any kind whose target has any bit of 31:9 set enters shared mode. In the next cycle curPc and sharedPtr both equal the target.
- R3: A taken branch whose target bits 31:9 are all zero enters local mode. In the next cycle curPc equals the target, with bits 31:9 reading zero.
- R4: A return (brKind=2'b10) takes the popped value as its target and picks the mode with the same bit 31:9 test. It saves no return value.
- R5: A plain call (brKind=2'b01) pulses saveValid with saveToReg=0 in the cycle after the request. saveValue is then the address of the next instruction after the caller.
- R6: A register-linked call (brKind=2'b11) behaves like R5, except that saveToReg=1 routes the value to the destination register.
- R7: In local mode the return value is the 9-bit local PC plus one, wrapping from 511 to 0, with bits 31:9 zero.
- R8: In shared mode the return value is the full 32-bit pointer plus one, with carry into the upper bits. A call in the last word of a window (for example 0x11FF) therefore saves the first word of the next window (0x1200).
- R9: stepEn with no branch advances the active PC by one without changing the mode. The local PC wraps within 9 bits.
- R10: When brValid and stepEn are both high in the same cycle, the branch wins and the step is dropped.
- R11: sharedPtr holds its last value while the core runs in local mode, including across local steps and local branches.
- R12: A jump (brKind=2'b00), a return, a step or an idle cycle leaves saveValid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brValid | input | 1 | Branch request taken this cycle |
| brKind | input | 2 | 00 jump, 01 call, 10 return, 11 register-linked call |
| brTarget | input | 32 | Branch target, popped value for a return |
| stepEn | input | 1 | Advance to the next sequential instruction |
| isShared | output | 1 | 1 when executing from shared memory |
| curPc | output | 32 | Active program counter |
| sharedPtr | output | 32 | Wide pointer used as PC in shared mode |
| saveValid | output | 1 | One-cycle pulse: a return value is presented |
| saveToReg | output | 1 | 1: value goes to destination register, 0: to stack |
| saveValue | output | 32 | Return address to be saved |

## Verification
Several rules are checked on every cycle: the mode and PC that follow each classified target, the return value in both modes including the 9-bit wrap, the absence of a save pulse after non-call requests, sequential stepping in shared mode, and that the shared pointer holds while the core is local. Other properties come out only in the bench's scenarios. These are chains of events: a call that leaves shared memory from the last word of a window and later returns into the following window, a register-linked value that is replayed as a return, and the exact boundary targets 0x1FF, 0x200 and 0x80000000.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_LINK = 2'b11
  } brKind_e;

  typedef struct packed {
    logic take;
    logic toShared;
    logic step;
    logic save;
    logic saveToReg;
  } xmStrobe_t;
endpackage

// File: rtl/xm_ctrl.sv
module xm_ctrl
  import xm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOCAL_AW = 9
) (
  input  logic              brValid,
  input  logic [1:0]        brKind,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              stepEn,
  output xmStrobe_t         strb
);
  localparam int UPPER_W = ADDR_W - LOCAL_AW;

  logic [UPPER_W-1:0] upperBits;
  logic upperHit;
  brKind_e kind;

  assign upperBits = brTarget[ADDR_W-1:LOCAL_AW];
  assign upperHit  = |upperBits;
  assign kind      = brKind_e'(brKind);

  always_comb begin
    strb           = '0;
    strb.take      = brValid;
    strb.toShared  = upperHit;
    strb.step      = stepEn & ~brValid;
    strb.save      = brValid & ((kind == BR_CALL) | (kind == BR_LINK));
    strb.saveToReg = brValid & (kind == BR_LINK);
  end
endmodule

// File: rtl/xm_dpath.sv
module xm_dpath
  import xm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOCAL_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  xmStrobe_t         strb,
  input  logic [ADDR_W-1:0] brTarget,
  output logic              isShared,
  output logic [ADDR_W-1:0] curPc,
  output logic [ADDR_W-1:0] sharedPtr,
  output logic              saveValid,
  output logic              saveToReg,
  output logic [ADDR_W-1:0] saveValue
);
  localparam int UPPER_W = ADDR_W - LOCAL_AW;

  logic                modeShared;
  logic [LOCAL_AW-1:0] localPc;
  logic [ADDR_W-1:0]   widePtr;
  logic [LOCAL_AW-1:0] localInc;
  logic [ADDR_W-1:0]   wideInc;
  logic [ADDR_W-1:0]   retAddr;
  logic                saveValidQ;
  logic                saveToRegQ;
  logic [ADDR_W-1:0]   saveValueQ;

  assign localInc = localPc + 1'b1;
  assign wideInc  = widePtr + 1'b1;
  assign retAddr  = modeShared ? wideInc : {{UPPER_W{1'b0}}, localInc};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeShared <= 1'b0;
      localPc    <= '0;
      widePtr    <= '0;
      saveValidQ <= 1'b0;
      saveToRegQ <= 1'b0;
      saveValueQ <= '0;
    end else begin
      if (strb.take) begin
        if (strb.toShared) begin
          modeShared <= 1'b1;
          widePtr    <= brTarget;
        end else begin
          modeShared <= 1'b0;
          localPc    <= brTarget[LOCAL_AW-1:0];
        end
      end else if (strb.step) begin
        if (modeShared) widePtr <= wideInc;
        else            localPc <= localInc;
      end
      saveValidQ <= strb.save;
      saveToRegQ <= strb.saveToReg;
      if (strb.save) saveValueQ <= retAddr;
    end
  end

  assign isShared  = modeShared;
  assign curPc     = modeShared ? widePtr : {{UPPER_W{1'b0}}, localPc};
  assign sharedPtr = widePtr;
  assign saveValid = saveValidQ;
  assign saveToReg = saveToRegQ;
  assign saveValue = saveValueQ;
endmodule

// File: rtl/xm_mode_switch.sv
module xm_mode_switch
  import xm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOCAL_AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brValid,
  input  logic [1:0]        brKind,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              stepEn,
  output logic              isShared,
  output logic [ADDR_W-1:0] curPc,
  output logic [ADDR_W-1:0] sharedPtr,
  output logic              saveValid,
  output logic              saveToReg,
  output logic [ADDR_W-1:0] saveValue
);
  xmStrobe_t strb;

  xm_ctrl #(.ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW)) u_ctrl (
    .brValid (brValid),
    .brKind  (brKind),
    .brTarget(brTarget),
    .stepEn  (stepEn),
    .strb    (strb)
  );

  xm_dpath #(.ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .brTarget (brTarget),
    .isShared (isShared),
    .curPc    (curPc),
    .sharedPtr(sharedPtr),
    .saveValid(saveValid),
    .saveToReg(saveToReg),
    .saveValue(saveValue)
  );
endmodule

// File: rtl/xm_mode_switch_chk.sv
module xm_mode_switch_chk #(
  parameter int ADDR_W   = 32,
  parameter int LOCAL_AW = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              brValid,
  input logic [1:0]        brKind,
  input logic [ADDR_W-1:0] brTarget,
  input logic              stepEn,
  input logic              isShared,
  input logic [ADDR_W-1:0] curPc,
  input logic [ADDR_W-1:0] sharedPtr,
  input logic              saveValid,
  input logic              saveToReg,
  input logic [ADDR_W-1:0] saveValue
);
  assert_enter_shared_R2: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && (brTarget[ADDR_W-1:LOCAL_AW] != '0))
      |=> (isShared && curPc == $past(brTarget) && sharedPtr == $past(brTarget)));

  assert_enter_local_R3: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && (brTarget[ADDR_W-1:LOCAL_AW] == '0))
      |=> (!isShared && curPc == $past(brTarget)));

  assert_call_to_stack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brKind == 2'b01) |=> (saveValid && !saveToReg));

  assert_link_to_reg_R6: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brKind == 2'b11) |=> (saveValid && saveToReg));

  assert_local_ret_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brKind[0] && !isShared)
      |=> (saveValue[ADDR_W-1:LOCAL_AW] == '0 &&
           saveValue[LOCAL_AW-1:0] == $past(curPc[LOCAL_AW-1:0]) + 1'b1));

  assert_shared_ret_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brKind[0] && isShared) |=> (saveValue == $past(curPc) + 1'b1));

  assert_shared_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!brValid && stepEn && isShared) |=> (isShared && curPc == $past(curPc) + 1'b1));

  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!isShared && !(brValid && (brTarget[ADDR_W-1:LOCAL_AW] != '0))) |=> $stable(sharedPtr));

  assert_no_save_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!brValid || !brKind[0]) |=> !saveValid);
endmodule

bind xm_mode_switch xm_mode_switch_chk #(.ADDR_W(ADDR_W), .LOCAL_AW(LOCAL_AW)) u_chk (
  .clk(clk), .rstN(rstN), .brValid(brValid), .brKind(brKind), .brTarget(brTarget),
  .stepEn(stepEn), .isShared(isShared), .curPc(curPc), .sharedPtr(sharedPtr),
  .saveValid(saveValid), .saveToReg(saveToReg), .saveValue(saveValue)
);

// File: tb/sim_xm_mode_switch.sv
`timescale 1ns/1ps
module sim_xm_mode_switch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        brValid = 1'b0;
  logic [1:0]  brKind = 2'b00;
  logic [31:0] brTarget = '0;
  logic        stepEn = 1'b0;
  logic        isShared;
  logic [31:0] curPc, sharedPtr, saveValue;
  logic        saveValid, saveToReg;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xm_mode_switch u0 (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brKind(brKind), .brTarget(brTarget),
    .stepEn(stepEn), .isShared(isShared), .curPc(curPc), .sharedPtr(sharedPtr),
    .saveValid(saveValid), .saveToReg(saveToReg), .saveValue(saveValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a request for one cycle; return at the following negedge.
  task automatic issue(input logic bv, input logic [1:0] k, input logic [31:0] t, input logic st);
    @(negedge clk);
    brValid = bv; brKind = k; brTarget = t; stepEn = st;
    @(negedge clk);
    brValid = 1'b0; stepEn = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode", {31'b0, isShared}, 32'd0);
    chk("R1 pc", curPc, 32'd0);
    chk("R1 ptr", sharedPtr, 32'd0);
    chk("R1 save", {31'b0, saveValid}, 32'd0);
  endtask

  task automatic t_local_jump_step;
    issue(1, 2'b00, 32'h1A5, 0);
    chk("R3 mode", {31'b0, isShared}, 32'd0);
    chk("R3 pc", curPc, 32'h1A5);
    chk("R12 jump no save", {31'b0, saveValid}, 32'd0);
    issue(0, 2'b00, 32'h0, 1);
    chk("R9 local step", curPc, 32'h1A6);
    issue(1, 2'b00, 32'h1FF, 0);
    chk("R3 boundary 0x1FF local", {31'b0, isShared}, 32'd0);
    issue(0, 2'b00, 32'h0, 1);
    chk("R9 local wrap", curPc, 32'h0);
    chk("R12 step no save", {31'b0, saveValid}, 32'd0);
  endtask

  task automatic t_call_local_to_shared;
    issue(1, 2'b00, 32'h1FF, 0);
    issue(1, 2'b01, 32'h0001_2340, 0);
    chk("R2 mode", {31'b0, isShared}, 32'd1);
    chk("R2 pc", curPc, 32'h0001_2340);
    chk("R2 ptr", sharedPtr, 32'h0001_2340);
    chk("R5 valid", {31'b0, saveValid}, 32'd1);
    chk("R5 to stack", {31'b0, saveToReg}, 32'd0);
    chk("R7 wrap value", saveValue, 32'h0);
    issue(0, 2'b00, 32'h0, 1);
    chk("R9 shared step", curPc, 32'h0001_2341);
    chk("R9 shared mode kept", {31'b0, isShared}, 32'd1);
  endtask

  task automatic t_link_window_edge;
    issue(1, 2'b00, 32'h0000_11FF, 0);
    chk("R2 shared 0x11FF", {31'b0, isShared}, 32'd1);
    issue(1, 2'b11, 32'h040, 0);
    chk("R6 valid", {31'b0, saveValid}, 32'd1);
    chk("R6 to reg", {31'b0, saveToReg}, 32'd1);
    chk("R8 next window", saveValue, 32'h0000_1200);
    chk("R3 local after link", curPc, 32'h040);
    chk("R11 ptr held", sharedPtr, 32'h0000_11FF);
    issue(0, 2'b00, 32'h0, 1);
    chk("R9 local step", curPc, 32'h041);
    chk("R11 ptr held over step", sharedPtr, 32'h0000_11FF);
    issue(1, 2'b00, 32'h077, 0);
    chk("R11 ptr held over local jump", sharedPtr, 32'h0000_11FF);
    issue(1, 2'b10, 32'h0000_1200, 0);
    chk("R4 return shared mode", {31'b0, isShared}, 32'd1);
    chk("R4 return pc", curPc, 32'h0000_1200);
    chk("R12 return no save", {31'b0, saveValid}, 32'd0);
    issue(1, 2'b10, 32'h0000_0123, 0);
    chk("R4 return local mode", {31'b0, isShared}, 32'd0);
    chk("R4 return local pc", curPc, 32'h123);
  endtask

  task automatic t_boundaries;
    issue(1, 2'b00, 32'h0000_0200, 0);
    chk("R2 bit9 shared", {31'b0, isShared}, 32'd1);
    chk("R2 bit9 pc", curPc, 32'h200);
    issue(1, 2'b01, 32'h8000_0000, 0);
    chk("R2 top bit shared", curPc, 32'h8000_0000);
    chk("R8 shared ret", saveValue, 32'h0000_0201);
    issue(1, 2'b01, 32'h0000_0010, 0);
    chk("R8 shared ret high", saveValue, 32'h8000_0001);
    chk("R3 local 0x10", curPc, 32'h10);
    issue(1, 2'b00, 32'h055, 1);
    chk("R10 branch beats step", curPc, 32'h055);
    issue(0, 2'b00, 32'h0, 0);
    chk("R12 idle no save", {31'b0, saveValid}, 32'd0);
    chk("R12 idle pc held", curPc, 32'h055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_local_jump_step;
    t_call_local_to_shared;
    t_link_window_edge;
    t_boundaries;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule